// File: doc/BRIEF.md
# Clock-Embedded Word-Boundary Deserializer

This block recovers parallel words from a two-wire source-synchronous serial link. One wire carries a forwarded serial clock and the other the data. Both wires are oversampled by a fast local clock and synchronized. A data bit is taken on each rising edge of the synchronized serial clock. The transmitter marks the end of a word by keeping the serial clock high for three bit times. During that hold it drives two extra boundary bits: first the complement of the last data bit, then the last data bit again. The data line therefore changes at least once while the serial clock is high, and nothing else on the link does that.

A frame is 24 data bits plus the two boundary bits. The boundary bits only locate the word and are never output. Of the 24 data bits, the two highest are always zero on the link and are dropped, so 22 payload bits reach the parallel port. The block loads a new word into the port and marks it with a low-going word clock pulse only when exactly 24 bits came before the boundary. A miscounted frame is discarded and reported on a one-cycle error flag. A link-enable input models shutdown: while it is low the block is held idle and cleared. When it rises, the word clock dips low for a fixed wake interval before normal operation begins.

States and transitions:
- `ST_OFF` goes to `ST_WAKE` when the link is enabled.
- `ST_WAKE` goes to `ST_COLLECT` when the wake interval expires.
- `ST_COLLECT` goes to `ST_HOLD` when a boundary is seen.
- `ST_HOLD` goes to `ST_COLLECT` on the falling edge of the serial clock.
- Any state goes to `ST_OFF` when the link is disabled.

Top module: `wbd_deser`

## Requirements
- R1: While `link_en` is low (shutdown), `word_clk` is high, `par_data` is all zeros and `frame_err` is low.
- R2: When `link_en` rises, `word_clk` goes low for exactly WAKE_CYC (default 4) clock cycles and then returns high.
- R3: A data bit is sampled on each rising edge of the synchronized serial clock. Bits are placed LSB first: the first bit of a frame appears at `par_data[0]` and the k-th bit at `par_data[k-1]`.
- R4: A change of the data line while the serial clock stays high is a word boundary. Only the first change in one high period counts, so each boundary yields at most one word or one error.
- R5: Only frame bits 1 to 22 are presented. Bits 23 and 24 and both boundary bits never reach `par_data`, whatever their values.
- R6: If the number of bits sampled since the last boundary is not exactly 24, the frame is dropped. `frame_err` pulses high for one cycle, `par_data` is unchanged and `word_clk` does not pulse.
- R7: On an accepted frame, `par_data` takes the new payload in the same cycle that `word_clk` falls. `word_clk` stays low for exactly STRB_CYC (default 2) cycles, so its rising edge marks stable data.
- R8: `par_data` keeps its last value until the next accepted frame, or until shutdown clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link enable; low holds the block in shutdown |
| ser_clk | input | 1 | Forwarded serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| par_data | output | 22 | Recovered payload word |
| word_clk | output | 1 | Word clock; idle high, low pulse on each new word |
| frame_err | output | 1 | One-cycle pulse for a dropped frame |

## Verification
The hardest situation to reach is a boundary that arrives after the wrong number of bits. A well-behaved transmitter never produces one, and a shutdown in the middle of a frame also resets the count. The bench's serial driver therefore takes an explicit bit count, so frames of 23 and 25 bits can be sent between good frames. A frame is also cut off by dropping the link enable partway through. Each case is followed by a normal frame to show that framing recovers.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAKE,
        ST_COLLECT,
        ST_HOLD
    } wbd_state_e;
endpackage

// File: rtl/wbd_sync.sv
module wbd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/wbd_shift.sv
module wbd_shift #(
    parameter int WORD_W = 24,
    parameter int PAY_W  = 22,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [PAY_W-1:0] word,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (shift_en && count != CNT_SAT) begin
            count <= count + 1'b1;
        end
    end

    // Bits past the payload width are counted but not stored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en && !clr) begin
            for (int i = 0; i < PAY_W; i++) begin
                if (count == CNT_W'(i)) word[i] <= bit_in;
            end
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_SAT);
endmodule

// File: rtl/wbd_deser.sv
module wbd_deser #(
    parameter int WORD_W      = 24,
    parameter int PAY_W       = 22,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYC    = 4,
    parameter int STRB_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic             ser_clk,
    input  logic             ser_dat,
    output logic [PAY_W-1:0] par_data,
    output logic             word_clk,
    output logic             frame_err
);
    import wbd_pkg::*;

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int TMR_MAX = (WAKE_CYC > STRB_CYC) ? WAKE_CYC : STRB_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    wbd_state_e       state, state_nxt;
    logic [1:0]       sync_out;
    logic             sclk_s, sdat_s, sclk_d, sdat_d;
    logic             rise, fall, bnd;
    logic             accept, err;
    logic             sh_clr, sh_en;
    logic [PAY_W-1:0] sh_word;
    logic [CNT_W-1:0] sh_cnt;
    logic [TMR_W-1:0] tmr;

    wbd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_dat, ser_clk}),
        .dout (sync_out)
    );
    assign sclk_s = sync_out[0];
    assign sdat_s = sync_out[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sdat_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sdat_d <= sdat_s;
        end
    end

    assign rise   = sclk_s && !sclk_d;
    assign fall   = !sclk_s && sclk_d;
    assign bnd    = sclk_s && sclk_d && (sdat_s ^ sdat_d);
    assign accept = (state == ST_COLLECT) && bnd && (sh_cnt == CNT_W'(WORD_W));
    assign err    = (state == ST_COLLECT) && bnd && (sh_cnt != CNT_W'(WORD_W));
    assign sh_en  = (state == ST_COLLECT) && rise;
    assign sh_clr = (state == ST_OFF) || (state == ST_WAKE) || ((state == ST_COLLECT) && bnd);

    wbd_shift #(.WORD_W(WORD_W), .PAY_W(PAY_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sh_clr),
        .shift_en(sh_en),
        .bit_in  (sdat_s),
        .word    (sh_word),
        .count   (sh_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:     if (link_en) state_nxt = ST_WAKE;
            ST_WAKE:    if (tmr == '0) state_nxt = ST_COLLECT;
            ST_COLLECT: if (bnd) state_nxt = ST_HOLD;
            ST_HOLD:    if (fall) state_nxt = ST_COLLECT;
        endcase
        if (!link_en) state_nxt = ST_OFF;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_data  <= '0;
            word_clk  <= 1'b1;
            frame_err <= 1'b0;
            tmr       <= '0;
        end else if (!link_en || state == ST_OFF) begin
            par_data  <= '0;
            frame_err <= 1'b0;
            if (link_en) begin
                word_clk <= 1'b0;
                tmr      <= TMR_W'(WAKE_CYC - 1);
            end else begin
                word_clk <= 1'b1;
                tmr      <= '0;
            end
        end else begin
            frame_err <= err;
            if (accept) begin
                par_data <= sh_word;
                word_clk <= 1'b0;
                tmr      <= TMR_W'(STRB_CYC - 1);
            end else if (!word_clk) begin
                if (tmr == '0) word_clk <= 1'b1;
                else           tmr <= tmr - 1'b1;
            end
        end
    end

    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!link_en) |-> (word_clk && par_data == '0 && !frame_err));
    p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_err, $fell(word_clk)}));
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $stable(par_data));
    p_strobe_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(par_data) && state != ST_OFF) |-> !word_clk);
endmodule

// File: tb/tb_wbd_deser.sv
module tb_wbd_deser;
    localparam int PAY_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_en = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [PAY_W-1:0] par_data;
    logic word_clk;
    logic frame_err;

    int checks = 0;
    int fails = 0;
    int falls = 0;
    int errs = 0;
    int run = 0;
    int last_low = 0;
    logic wc_prev = 1'b1;
    logic [PAY_W-1:0] exp_word = '0;

    always #4 clk = ~clk;

    wbd_deser dut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .ser_clk(ser_clk), .ser_dat(ser_dat),
        .par_data(par_data), .word_clk(word_clk), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!word_clk) run <= run + 1;
        else if (run != 0) begin
            last_low <= run;
            run <= 0;
        end
        if (wc_prev && !word_clk) falls <= falls + 1;
        if (frame_err) errs <= errs + 1;
        wc_prev <= word_clk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send_bits(input logic [25:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_clk = 1'b0;
            ser_dat = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic send_bnd(input logic last);
        ser_dat = ~last;
        repeat (8) @(negedge clk);
        ser_dat = last;
        repeat (8) @(negedge clk);
        ser_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic good_word(input logic [23:0] w, input string req);
        int f0, e0;
        f0 = falls;
        e0 = errs;
        send_bits({2'b00, w}, 24);
        send_bnd(w[23]);
        exp_word = w[PAY_W-1:0];
        chk(par_data == exp_word, req, par_data, exp_word);
        chk(falls - f0 == 1, {req, " strobe count"}, falls - f0, 1);
        chk(errs == e0, {req, " no error"}, errs - e0, 0);
        chk(last_low == 2, "R7 strobe width", last_low, 2);
    endtask

    task automatic bad_word(input logic [25:0] w, input int n);
        int f0, e0;
        f0 = falls;
        e0 = errs;
        send_bits(w, n);
        send_bnd(w[n-1]);
        chk(errs - e0 == 1, "R6 error pulse", errs - e0, 1);
        chk(falls == f0, "R6 no strobe", falls - f0, 0);
        chk(par_data == exp_word, "R6 R8 data held", par_data, exp_word);
    endtask

    task automatic wake();
        int f0;
        f0 = falls;
        @(negedge clk);
        link_en = 1'b1;
        repeat (12) @(negedge clk);
        chk(falls - f0 == 1, "R2 wake dip", falls - f0, 1);
        chk(last_low == 4, "R2 wake width", last_low, 4);
        chk(word_clk == 1'b1, "R2 returns high", word_clk, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_clk == 1'b1, "R1 idle clock", word_clk, 1);
        chk(par_data == '0, "R1 idle data", par_data, 0);
        chk(frame_err == 1'b0, "R1 idle error", frame_err, 0);

        wake();

        // R3 walking ones: bit position k lands at par_data[k]
        for (int k = 0; k < PAY_W; k++) good_word(24'(1) << k, "R3 walking one");
        good_word(24'h3FFFFF, "R3 all ones");
        good_word(24'h155555, "R4 alternating");
        good_word(24'h2AAAAA, "R4 alternating inverse");
        good_word(24'h000000, "R3 zero word");
        // R5 upper frame bits set: discarded
        good_word(24'hC0ABCD, "R5 upper bits dropped");

        bad_word(26'h0123456, 23);
        good_word(24'h11F0E1, "R6 recovery after short");
        bad_word(26'h2345678, 25);
        good_word(24'h0F0F0F, "R6 recovery after long");

        // R1 shutdown in mid-frame
        send_bits(26'h0000FFF, 10);
        @(negedge clk);
        link_en = 1'b0;
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk(word_clk == 1'b1, "R1 shutdown clock", word_clk, 1);
        chk(par_data == '0, "R1 shutdown data", par_data, 0);
        exp_word = '0;
        wake();
        good_word(24'h2DBEEF, "R8 after re-wake");
        repeat (50) @(negedge clk);
        chk(par_data == exp_word, "R8 holds when idle", par_data, exp_word);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule